// File: doc/BRIEF.md
# Descriptor-Tracked Packet Receive Buffer

This block stores received packets in a byte-wide circular RAM and keeps a fixed table of eight descriptor slots, one per stored packet. A write-side stream delivers packet bytes with start and end markers. Each byte is stored at a working offset past the committed tail. At the end of a good packet, the packet's start address, length and an information byte are committed into the next slot, and the tail moves past the packet. Bad packets are dropped whole and roll back to the committed tail. Packets that meet a full buffer are dropped in the same way.

A host reads the oldest stored packet through a single data register. Each read returns one byte and advances the head by one. Reading the final byte of a packet frees its slot. The host can also:
- discard the current packet or every stored packet;
- inspect the current slot number, the valid-slot bitmap, the current packet's length and information byte, and the head and tail pointers;
- read and clear a two-bit cause register. The cause register tells whether running out of ring space or running out of slots raised the full interrupt.

Top module: `pkt_rx_buffer`

## Requirements
- R1: After reset:
  - the valid bitmap, the current slot, the head, the tail and the cause register all read zero;
  - `irqFull` is low.
- R2: A packet that ends with `rxGood` high is committed into slots in circular order starting at slot 0, and sets that slot's bit in the valid bitmap (offset 2, bit n = slot n). The current packet's length reads at offset 5 (low byte) and offset 6 (high byte). Its information byte reads at offset 7. The tail (offset 9) advances by the packet length modulo the ring size.
- R3: A host read of offset 0 returns the next byte of the current (oldest) packet one cycle later, and the head (offset 8) advances by one. Reading the last byte frees that slot, and the current slot moves to the next one.
- R4: Offset 1 reads the current slot number in bits 2..0 with zeros above. Host writes to offset 1 have no effect.
- R5: Writing offset 3 with bit 0 set and bit 1 clear discards the current packet. This clears its valid bit, moves the head to the first byte of the next packet and advances the current slot. With no stored packet it has no effect.
- R6: Writing offset 3 with bit 1 set discards every packet. The valid bitmap becomes zero, the head equals the tail, and the current slot becomes the next slot to be filled.
- R7: A packet that ends with `rxGood` low commits no slot and leaves the tail unchanged.
- R8: Cause bit 0 (offset 4) is set when a stored byte uses the last free ring byte. It is also set when a byte meets a full ring. In the second case the whole packet is dropped: no slot is committed and the tail is unchanged.
- R9: Cause bit 1 is set when a commit fills the eighth slot. It is also set when a packet starts while all eight slots are valid. Such a packet is dropped whole.
- R10: Cause bits stay set until the host writes 1 to them at offset 4. `irqFull` is high exactly while any cause bit is set.
- R11: A read of offset 0 with no stored packet returns 0 and moves neither the head nor the current slot.
- R12: Ring addresses wrap modulo the ring size (256 bytes by default). Packets that straddle the end of the ring read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Write-side byte strobe |
| rxData | input | 8 | Write-side packet byte |
| rxSop | input | 1 | Byte is the first of a packet |
| rxEop | input | 1 | Byte is the last of a packet |
| rxGood | input | 1 | Packet status, sampled with the last byte |
| rxInfo | input | INFO_W | Information byte stored with the packet at commit |
| hostRd | input | 1 | Host register read strobe |
| hostWr | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host register offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, valid the cycle after `hostRd` |
| irqFull | output | 1 | Buffer-full interrupt |

## Verification
The assertions take the following for granted about the inputs:
- `rxSop` and `rxEop` are qualified by `rxValid`;
- the host never raises read and write in the same cycle;
- packets are only read or discarded through the host registers.

Under these conditions the committed byte count never exceeds the ring. A commit never lands on an occupied slot, unless a discard-all is happening in the same cycle.

The stimulus keeps within these conditions by never overlapping host and write-side traffic and by driving every strobe from one task at a time. Random packet lengths, good/bad mixes, partial reads and discards are mixed with directed runs that fill all eight slots, overflow the ring, fill it exactly, and read a packet across the wrap point.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef struct packed {
    logic memWe;
    logic headInc;
    logic headLoad;
    logic headToTail;
    logic tailAdv;
  } dpStrobe_t;

  localparam logic [3:0] REG_DATA  = 4'h0;
  localparam logic [3:0] REG_SLOT  = 4'h1;
  localparam logic [3:0] REG_VALID = 4'h2;
  localparam logic [3:0] REG_CTRL  = 4'h3;
  localparam logic [3:0] REG_CAUSE = 4'h4;
  localparam logic [3:0] REG_LENLO = 4'h5;
  localparam logic [3:0] REG_LENHI = 4'h6;
  localparam logic [3:0] REG_INFO  = 4'h7;
  localparam logic [3:0] REG_HEAD  = 4'h8;
  localparam logic [3:0] REG_TAIL  = 4'h9;

  localparam int CTRL_DROP_ONE = 0;
  localparam int CTRL_DROP_ALL = 1;
  localparam int CAUSE_RING    = 0;
  localparam int CAUSE_SLOT    = 1;

endpackage

// File: rtl/pkt_rx_dp.sv
module pkt_rx_dp
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DW-1:0]     memData,
  input  logic [ADDR_W-1:0] headVal,
  input  logic [ADDR_W:0]   tailStep,
  output logic [ADDR_W-1:0] head,
  output logic [ADDR_W-1:0] tail,
  output logic [DW-1:0]     headByte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[memAddr] <= memData;
  end

  assign headByte = mem[head];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (strobe.headToTail)    head <= tail;
      else if (strobe.headLoad) head <= headVal;
      else if (strobe.headInc)  head <= head + 1'b1;
      if (strobe.tailAdv) tail <= tail + tailStep[ADDR_W-1:0];
    end
  end

  // R12: the head steps from the last ring address back to address zero.
  a_r12_head_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.headInc && !strobe.headLoad && !strobe.headToTail && (&head))
      |=> (head == '0));

endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SLOTS  = 8,
  parameter int INFO_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              rxGood,
  input  logic [INFO_W-1:0] rxInfo,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [3:0]        hostAddr,
  input  logic [DW-1:0]     hostWdata,
  output logic [DW-1:0]     hostRdata,
  output logic              irqFull,
  input  logic [ADDR_W-1:0] head,
  input  logic [ADDR_W-1:0] tail,
  input  logic [DW-1:0]     headByte,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] headVal,
  output logic [ADDR_W:0]   tailStep
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LEN_W  = ADDR_W + 1;
  localparam int SUM_W  = LEN_W + 1;
  localparam int SLOT_W = $clog2(SLOTS);

  // Descriptor table, one entry per slot
  logic [SLOTS-1:0][ADDR_W-1:0] startAll;
  logic [SLOTS-1:0][LEN_W-1:0]  lenAll;
  logic [SLOTS-1:0][INFO_W-1:0] infoAll;
  logic [SLOTS-1:0]             validMap, validNext;

  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [LEN_W-1:0]  rdOff, usedCount, usedNext, pktLen;
  logic              dropping;
  logic [1:0]        cause, causeSet, causeClr;

  // Host side decode
  logic hostRdEn, curValid, dataRead, lastByte, discardOne, clearAll, freeCur;
  logic [LEN_W-1:0] curLen;

  assign hostRdEn   = hostRd && !hostWr;
  assign curValid   = validMap[rdSlot];
  assign curLen     = lenAll[rdSlot];
  assign dataRead   = hostRdEn && (hostAddr == REG_DATA) && curValid;
  assign lastByte   = dataRead && (rdOff == LEN_W'(curLen - 1'b1));
  assign clearAll   = hostWr && (hostAddr == REG_CTRL) && hostWdata[CTRL_DROP_ALL];
  assign discardOne = hostWr && (hostAddr == REG_CTRL) && hostWdata[CTRL_DROP_ONE]
                      && !hostWdata[CTRL_DROP_ALL] && curValid;
  assign freeCur    = lastByte || discardOne;

  // Write side
  logic             slotsFull, dropNow, spaceOk, storeByte, overflowNow, commit, fillHit;
  logic [LEN_W-1:0] baseLen, newLen;

  assign slotsFull   = &validMap;
  assign baseLen     = rxSop ? '0 : pktLen;
  assign dropNow     = rxSop ? slotsFull : dropping;
  assign spaceOk     = ({1'b0, usedCount} + {1'b0, baseLen}) < SUM_W'(DEPTH);
  assign storeByte   = rxValid && !dropNow && spaceOk;
  assign overflowNow = rxValid && !dropNow && !spaceOk;
  assign newLen      = baseLen + LEN_W'(storeByte);
  assign commit      = storeByte && rxEop && rxGood;
  assign fillHit     = ({1'b0, usedCount} + {1'b0, newLen}) == SUM_W'(DEPTH);

  // Strobes and values to the datapath
  always_comb begin
    strobe            = '0;
    strobe.memWe      = storeByte;
    strobe.headInc    = dataRead;
    strobe.headLoad   = discardOne;
    strobe.headToTail = clearAll;
    strobe.tailAdv    = commit;
  end
  assign memAddr  = tail + baseLen[ADDR_W-1:0];
  assign headVal  = startAll[rdSlot] + curLen[ADDR_W-1:0];
  assign tailStep = newLen;

  always_comb begin
    validNext = validMap;
    if (clearAll)     validNext = '0;
    else if (freeCur) validNext[rdSlot] = 1'b0;
    if (commit)       validNext[wrSlot] = 1'b1;
  end

  always_comb begin
    usedNext = usedCount;
    if (clearAll) usedNext = '0;
    else begin
      if (dataRead)   usedNext = usedNext - 1'b1;
      if (discardOne) usedNext = usedNext - (curLen - rdOff);
    end
    if (commit) usedNext = usedNext + newLen;
  end

  assign causeSet[CAUSE_RING] = (storeByte && fillHit) || overflowNow;
  assign causeSet[CAUSE_SLOT] = (rxValid && rxSop && slotsFull) || (commit && (&validNext));
  assign causeClr = (hostWr && (hostAddr == REG_CAUSE)) ? hostWdata[1:0] : 2'b00;
  assign irqFull  = |cause;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : gSlot
      logic [ADDR_W-1:0] startQ;
      logic [LEN_W-1:0]  lenQ;
      logic [INFO_W-1:0] infoQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startQ <= '0;
          lenQ   <= '0;
          infoQ  <= '0;
        end else if (commit && (wrSlot == SLOT_W'(g))) begin
          startQ <= tail;
          lenQ   <= newLen;
          infoQ  <= rxInfo;
        end
      end
      assign startAll[g] = startQ;
      assign lenAll[g]   = lenQ;
      assign infoAll[g]  = infoQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMap  <= '0;
      wrSlot    <= '0;
      rdSlot    <= '0;
      rdOff     <= '0;
      usedCount <= '0;
      pktLen    <= '0;
      dropping  <= 1'b1;
      cause     <= '0;
    end else begin
      validMap  <= validNext;
      usedCount <= usedNext;
      if (commit) wrSlot <= wrSlot + 1'b1;
      if (clearAll) begin
        rdSlot <= wrSlot;
        rdOff  <= '0;
      end else if (freeCur) begin
        rdSlot <= rdSlot + 1'b1;
        rdOff  <= '0;
      end else if (dataRead) begin
        rdOff <= rdOff + 1'b1;
      end
      if (rxValid) begin
        pktLen   <= rxEop ? '0 : newLen;
        dropping <= rxEop || dropNow || overflowNow;
      end
      cause <= (cause & ~causeClr) | causeSet;
    end
  end

  // Host read data, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdata <= '0;
    else if (hostRdEn) begin
      case (hostAddr)
        REG_DATA:  hostRdata <= curValid ? headByte : '0;
        REG_SLOT:  hostRdata <= DW'(rdSlot);
        REG_VALID: hostRdata <= DW'(validMap);
        REG_CAUSE: hostRdata <= DW'(cause);
        REG_LENLO: hostRdata <= curValid ? DW'(curLen) : '0;
        REG_LENHI: hostRdata <= curValid ? DW'(curLen >> 8) : '0;
        REG_INFO:  hostRdata <= curValid ? DW'(infoAll[rdSlot]) : '0;
        REG_HEAD:  hostRdata <= DW'(head);
        REG_TAIL:  hostRdata <= DW'(tail);
        default:   hostRdata <= '0;
      endcase
    end
  end

  // R2 / R7: the tail only moves on a committed packet.
  a_r2_tail_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tailAdv |=> $stable(tail));

  // R9: a commit always targets a free slot.
  a_r9_commit_free_slot: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !clearAll) |-> !validMap[wrSlot]);

  // R8: committed bytes never exceed the ring.
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    usedCount <= LEN_W'(DEPTH));

  // R3 / R11: the head only steps while a packet is stored.
  a_r3_read_needs_packet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.headInc |-> (validMap != '0));

  // R6: discard-all empties the bitmap.
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (clearAll && !commit) |=> (validMap == '0));

  // R10: a ring cause bit holds until cleared.
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cause[CAUSE_RING] && !causeClr[CAUSE_RING]) |=> cause[CAUSE_RING]);

endmodule

// File: rtl/pkt_rx_buffer.sv
module pkt_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SLOTS  = 8,
  parameter int INFO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              rxGood,
  input  logic [INFO_W-1:0] rxInfo,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [3:0]        hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              irqFull
);
  localparam int DW = 8;

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] head, tail, memAddr, headVal;
  logic [ADDR_W:0]   tailStep;
  logic [DW-1:0]     headByte;

  pkt_rx_ctrl #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS), .INFO_W(INFO_W), .DW(DW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop), .rxGood(rxGood), .rxInfo(rxInfo),
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irqFull(irqFull),
    .head(head), .tail(tail), .headByte(headByte),
    .strobe(strobe), .memAddr(memAddr), .headVal(headVal), .tailStep(tailStep)
  );

  pkt_rx_dp #(
    .ADDR_W(ADDR_W), .DW(DW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memAddr(memAddr), .memData(rxData), .headVal(headVal), .tailStep(tailStep),
    .head(head), .tail(tail), .headByte(headByte)
  );

endmodule

// File: tb/pkt_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module pkt_rx_buffer_tb_top;
  localparam int RING = 256;
  localparam int NS   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0, rxSop = 1'b0, rxEop = 1'b0, rxGood = 1'b0;
  logic [7:0] rxData = '0, rxInfo = '0;
  logic hostRd = 1'b0, hostWr = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic irqFull;

  always #4 clk = ~clk;

  pkt_rx_buffer dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxSop(rxSop),
    .rxEop(rxEop), .rxGood(rxGood), .rxInfo(rxInfo), .hostRd(hostRd), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata), .irqFull(irqFull)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model
  logic [7:0] mRing [RING];
  int mHead = 0, mTail = 0, mUsed = 0, mWr = 0, mRd = 0, mOff = 0, mCause = 0;
  bit mValid [NS];
  int mLen [NS], mInfo [NS];

  function automatic bit allValid();
    for (int i = 0; i < NS; i++) if (!mValid[i]) return 0;
    return 1;
  endfunction

  function automatic int validBits();
    int v = 0;
    for (int i = 0; i < NS; i++) if (mValid[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic hostWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk); hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWr = 0; hostWdata = '0;
  endtask

  task automatic hostRead(logic [3:0] a, output int v);
    @(negedge clk); hostRd = 1; hostAddr = a;
    @(negedge clk); hostRd = 0; v = int'(hostRdata);
  endtask

  task automatic sendPacket(int len, bit good, int info);
    int pend = 0;
    bit drop = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk);
      rxValid = 1; rxData = b; rxSop = (i == 0); rxEop = (i == len - 1);
      rxGood = good; rxInfo = 8'(info);
      if (i == 0) begin
        pend = 0;
        drop = allValid();
        if (drop) mCause |= 2;
      end
      if (!drop) begin
        if (mUsed + pend >= RING) begin
          drop = 1; mCause |= 1;
        end else begin
          mRing[(mTail + pend) % RING] = b;
          pend++;
          if (mUsed + pend == RING) mCause |= 1;
        end
      end
      if (i == len - 1 && !drop && good) begin
        mValid[mWr] = 1; mLen[mWr] = pend; mInfo[mWr] = info;
        mUsed += pend; mTail = (mTail + pend) % RING; mWr = (mWr + 1) % NS;
        if (allValid()) mCause |= 2;
      end
    end
    @(negedge clk); rxValid = 0; rxSop = 0; rxEop = 0;
  endtask

  task automatic readData(string req);
    int v, e;
    bit had = mValid[mRd];
    hostRead(4'h0, v);
    if (had) begin
      e = int'(mRing[mHead]);
      mHead = (mHead + 1) % RING; mUsed--; mOff++;
      if (mOff == mLen[mRd]) begin
        mValid[mRd] = 0; mRd = (mRd + 1) % NS; mOff = 0;
      end
      chk(req, v, e, "data byte");
    end else chk("R11", v, 0, "empty data read");
  endtask

  task automatic discardOne();
    hostWrite(4'h3, 8'h01);
    if (mValid[mRd]) begin
      mUsed -= mLen[mRd] - mOff;
      mHead = (mHead + mLen[mRd] - mOff) % RING;
      mValid[mRd] = 0; mRd = (mRd + 1) % NS; mOff = 0;
    end
  endtask

  task automatic discardAll();
    hostWrite(4'h3, 8'h02);
    for (int i = 0; i < NS; i++) mValid[i] = 0;
    mHead = mTail; mUsed = 0; mRd = mWr; mOff = 0;
  endtask

  task automatic clearCause(int bits);
    hostWrite(4'h4, 8'(bits));
    mCause &= ~bits;
  endtask

  task automatic checkRegs(string req);
    int v;
    bit cv = mValid[mRd];
    hostRead(4'h1, v); chk(req, v, mRd, "current slot (R4)");
    hostRead(4'h2, v); chk(req, v, validBits(), "valid bitmap (R2)");
    hostRead(4'h4, v); chk(req, v, mCause, "cause (R10)");
    hostRead(4'h8, v); chk(req, v, mHead, "head (R3)");
    hostRead(4'h9, v); chk(req, v, mTail, "tail (R2)");
    hostRead(4'h5, v); chk(req, v, cv ? (mLen[mRd] & 255) : 0, "length low (R2)");
    hostRead(4'h6, v); chk(req, v, cv ? (mLen[mRd] >> 8) : 0, "length high (R2)");
    hostRead(4'h7, v); chk(req, v, cv ? mInfo[mRd] : 0, "info (R2)");
    chk(req, int'(irqFull), (mCause != 0) ? 1 : 0, "irqFull (R10)");
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin mValid[i] = 0; mLen[i] = 0; mInfo[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;

    checkRegs("R1");
    readData("R11");
    checkRegs("R11");
    hostWrite(4'h1, 8'hFF);
    checkRegs("R4");

    sendPacket(1, 1, 8'h5A);
    checkRegs("R2");
    readData("R3");
    checkRegs("R3");

    sendPacket(10, 0, 8'h11);
    checkRegs("R7");
    discardOne();
    checkRegs("R5");

    for (int k = 0; k < NS; k++) sendPacket(5 + k, 1, k + 1);
    checkRegs("R9");
    sendPacket(4, 1, 8'h99);
    checkRegs("R9");
    clearCause(2);
    checkRegs("R10");
    readData("R3"); readData("R3");
    discardOne();
    checkRegs("R5");
    discardOne();
    checkRegs("R5");
    discardAll();
    checkRegs("R6");

    for (int k = 0; k < 4; k++) sendPacket(70, 1, 8'h40 + k);
    checkRegs("R8");
    discardAll();
    clearCause(3);
    checkRegs("R10");
    sendPacket(RING, 1, 8'h77);
    checkRegs("R8");
    for (int k = 0; k < RING; k++) readData("R12");
    checkRegs("R12");
    clearCause(3);

    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 19);
      if (op < 8) sendPacket($urandom_range(1, 60), ($urandom_range(0, 7) != 0), $urandom_range(0, 255));
      else if (op < 13) begin
        int n = $urandom_range(1, 20);
        for (int k = 0; k < n; k++) readData("R3");
      end
      else if (op < 16) discardOne();
      else if (op == 16) discardAll();
      else if (op == 17) clearCause($urandom_range(1, 3));
      else checkRegs("R12");
    end
    checkRegs("R2");
    finishRun();
  end

endmodule